// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes the level-sensitive interrupt requests of a small set of PCI devices and steers each one onto two destinations at the same time. One is a programmable line of a 16-line ISA interrupt vector. The other is a fixed input of an IOAPIC. A request's target is chosen by a rotation of its interrupt pin by its device number. The rotation folds every request onto one of four shared PCI interrupt lanes, called lanes A to D here.

Each lane has a routing register in a byte-addressed configuration window. The register decides which ISA line the lane drives, or whether the lane's legacy path is off. The IOAPIC path does not depend on these registers: lanes A to D always drive IOAPIC inputs 17 to 20. A fifth register holds the motherboard device route and is kept for software to read back.

The two output paths are registered and deliberately skewed by one cycle. The ISA line rises a cycle before the IOAPIC line, and the IOAPIC line falls a cycle before the ISA line.

Top module: `pirq_router`

## Requirements
- R1: After reset, the routing registers at offsets 0x60, 0x61, 0x62 and 0x63 (lanes A, B, C, D) and the motherboard route register at 0x70 read 0x80. All ISA and IOAPIC outputs are low.
- R2: A request from device number N on pin P, where P is 1 to 4 for INTA to INTD, selects lane ((P-1)+(N-1)) mod 4. Lane i drives `ioapic_irq[i]`, which stands for IOAPIC input 17+i.
- R3: A lane's IOAPIC output is asserted whenever any request selects that lane, whatever its routing register holds. The output stays high until the last request on that lane drops.
- R4: Routing register bits 3:0 name the ISA line that the lane drives. When the register value is 16 or more (bit 7 set), the lane drives no ISA line.
- R5: Each ISA line is the OR of every enabled lane routed to it.
- R6: Take edge E as the first clock edge that samples a request high. The ISA line is high after edge E+1 and the IOAPIC line is high after edge E+2. Take edge F as the first edge that samples the request low. The IOAPIC line is low after edge F+1 and the ISA line is low after edge F+2. A request must be held at least two cycles to reach the IOAPIC line.
- R7: A write to a routing register is stored at the write edge. Outputs reflect the new value at the next edge: the old ISA line falls and the new one rises on that same edge, with no cycle in which both are high.
- R8: Offsets other than 0x60 to 0x63 and 0x70 read as zero. Writes to those offsets change no register and no output.
- R9: A write stores only bits 7 and 3:0 of a routing register or of the motherboard route register. Bits 6:4 always read back as zero.
- R10: A request whose pin value is 0 (no interrupt pin) or 5 to 7 asserts no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr`, combinational |
| dev_num | input | NUM_DEV x DEVNUM_W | Device number of each request source |
| dev_pin | input | NUM_DEV x 3 | Interrupt pin of each source (1..4 = INTA..INTD) |
| dev_req | input | NUM_DEV | Request level of each source |
| isa_irq | output | 16 | Registered ISA interrupt levels |
| ioapic_irq | output | 4 | Registered IOAPIC levels for inputs 17..20 |

## Verification
The bench counts edges around each request and checks the one-cycle skew in both directions. A design that drove both paths together, or reversed the order on release, would show equal levels at the sampled cycles.

It rewrites a live route and checks the cycle in which both ISA lines are seen. A design with an extra pipeline stage would hold the old line, and a mis-merged one would show both lines high at once.

It exercises the swizzle with device numbers whose sum wraps past four, including device number zero. It also shares one lane between two sources and one ISA line between two lanes. A design that used the last request instead of the OR would drop the line early.

Disabled routes, pin values 0 and above 4, writes to unimplemented offsets and writes of ones into reserved bits are each checked at the outputs or by read-back. These catch a design that leaked a request through, or that let any of those writes change stored state.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  // Number of shared PCI interrupt lanes; the swizzle is modulo this count.
  localparam int LANES = 4;
  // Width of the legacy interrupt vector.
  localparam int ISA_LINES = 16;
  // Width of a configuration register.
  localparam int REG_W = 8;
  // Width of a device pin code.
  localparam int PIN_W = 3;

  typedef logic [REG_W-1:0] cfg_byte_t;

  localparam cfg_byte_t ROUTE_RESET = 8'h80;

  // Keeps the enable bit and the line number, clears the reserved bits.
  function automatic cfg_byte_t keep_route_fields(input cfg_byte_t raw);
    return {raw[7], 3'b000, raw[3:0]};
  endfunction

  // True for pin codes INTA..INTD.
  function automatic logic pin_is_valid(input logic [PIN_W-1:0] pin);
    return (pin >= 3'd1) && (pin <= 3'd4);
  endfunction

endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ROUTE_BASE = 'h60,
  parameter logic [ADDR_W-1:0] MB_OFFSET = 'h70
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_wr,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  cfg_byte_t                   cfg_wdata,
  output cfg_byte_t                   cfg_rdata,
  output logic [LANES-1:0][REG_W-1:0] route_q
);

  logic [LANES-1:0] route_hit;
  logic             mb_hit;
  cfg_byte_t        mb_q;

  assign mb_hit = (cfg_addr == MB_OFFSET);

  for (genvar p = 0; p < LANES; p++) begin : g_route
    localparam logic [ADDR_W-1:0] OFF = ROUTE_BASE + ADDR_W'(p);
    assign route_hit[p] = (cfg_addr == OFF);

    always_ff @(posedge clk) begin
      if (rst) begin
        route_q[p] <= ROUTE_RESET;
      end else if (cfg_wr && route_hit[p]) begin
        route_q[p] <= keep_route_fields(cfg_wdata);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mb_q <= ROUTE_RESET;
    end else if (cfg_wr && mb_hit) begin
      mb_q <= keep_route_fields(cfg_wdata);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int p = 0; p < LANES; p++) begin
      if (route_hit[p]) cfg_rdata = route_q[p];
    end
    if (mb_hit) cfg_rdata = mb_q;
  end

endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
  import pirq_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEVNUM_W = 5
) (
  input  logic [NUM_DEV-1:0][DEVNUM_W-1:0] dev_num,
  input  logic [NUM_DEV-1:0][PIN_W-1:0]    dev_pin,
  input  logic [NUM_DEV-1:0]               dev_req,
  output logic [LANES-1:0]                 lane_lvl
);

  logic [NUM_DEV-1:0][LANES-1:0] dev_hit;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    int unsigned lane_idx;
    // ((pin-1)+(num-1)) mod 4, with -2 folded into +2 modulo four.
    assign lane_idx = (int'(dev_num[d]) + int'(dev_pin[d]) + 2) % LANES;

    always_comb begin
      dev_hit[d] = '0;
      if (dev_req[d] && pin_is_valid(dev_pin[d])) begin
        dev_hit[d][lane_idx] = 1'b1;
      end
    end
  end

  always_comb begin
    lane_lvl = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      lane_lvl = lane_lvl | dev_hit[d];
    end
  end

endmodule

// File: rtl/pirq_isa_map.sv
module pirq_isa_map
  import pirq_pkg::*;
(
  input  logic [LANES-1:0]            lane_lvl,
  input  logic [LANES-1:0][REG_W-1:0] route_q,
  output logic [ISA_LINES-1:0]        isa_next
);

  always_comb begin
    isa_next = '0;
    for (int p = 0; p < LANES; p++) begin
      if (lane_lvl[p] && (route_q[p] < REG_W'(ISA_LINES))) begin
        isa_next[route_q[p][3:0]] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEVNUM_W = 5,
  parameter int ADDR_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_wr,
  input  logic [ADDR_W-1:0]                cfg_addr,
  input  logic [7:0]                       cfg_wdata,
  output logic [7:0]                       cfg_rdata,
  input  logic [NUM_DEV-1:0][DEVNUM_W-1:0] dev_num,
  input  logic [NUM_DEV-1:0][2:0]          dev_pin,
  input  logic [NUM_DEV-1:0]               dev_req,
  output logic [15:0]                      isa_irq,
  output logic [3:0]                       ioapic_irq
);

  localparam logic [ADDR_W-1:0] ROUTE_BASE = ADDR_W'('h60);
  localparam logic [ADDR_W-1:0] MB_OFFSET = ADDR_W'('h70);

  logic [LANES-1:0][REG_W-1:0] route_q;
  logic [LANES-1:0]            lane_now;
  logic [LANES-1:0]            lane_q;
  logic [LANES-1:0]            lane_d;
  logic [ISA_LINES-1:0]        isa_next;
  logic [ISA_LINES-1:0]        isa_q;
  logic [LANES-1:0]            io_q;

  pirq_cfg_regs #(
    .ADDR_W    (ADDR_W),
    .ROUTE_BASE(ROUTE_BASE),
    .MB_OFFSET (MB_OFFSET)
  ) regs_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .route_q  (route_q)
  );

  pirq_swizzle #(
    .NUM_DEV (NUM_DEV),
    .DEVNUM_W(DEVNUM_W)
  ) swz_i (
    .dev_num (dev_num),
    .dev_pin (dev_pin),
    .dev_req (dev_req),
    .lane_lvl(lane_now)
  );

  // Legacy path sees the lane while either stage holds it: early rise, late fall.
  pirq_isa_map map_i (
    .lane_lvl(lane_q | lane_d),
    .route_q (route_q),
    .isa_next(isa_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q <= '0;
      lane_d <= '0;
      isa_q  <= '0;
      io_q   <= '0;
    end else begin
      lane_q <= lane_now;
      lane_d <= lane_q;
      isa_q  <= isa_next;
      // IOAPIC path needs both stages: late rise, early fall.
      io_q   <= lane_q & lane_d;
    end
  end

  assign isa_irq    = isa_q;
  assign ioapic_irq = io_q;

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int NUM_DEV = 4,
  parameter int ADDR_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     cfg_addr,
  input logic [7:0]            cfg_rdata,
  input logic [NUM_DEV-1:0]    dev_req,
  input logic [15:0]           isa_irq,
  input logic [3:0]            ioapic_irq,
  input logic [3:0][7:0]       route_q
);

  logic addr_impl;
  assign addr_impl = (cfg_addr >= ADDR_W'('h60) && cfg_addr <= ADDR_W'('h63)) ||
                     (cfg_addr == ADDR_W'('h70));

  // R1: a reset cycle leaves every output low.
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (isa_irq == '0 && ioapic_irq == '0));

  // R8: unimplemented offsets read as zero.
  a_r8_unimpl_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !addr_impl |-> (cfg_rdata == 8'h00));

  // R9: reserved bits never read as one.
  a_r9_reserved_clear: assert property (@(posedge clk) disable iff (rst)
    addr_impl |-> (cfg_rdata[6:4] == 3'b000));

  for (genvar p = 0; p < 4; p++) begin : g_lane
    // R6: the IOAPIC line rises only after two sampled cycles of request.
    a_r6_io_rise_needs_req: assert property (@(posedge clk) disable iff (rst)
      $rose(ioapic_irq[p]) |-> ($past(|dev_req, 2) && $past(|dev_req, 3)));

    // R6: when the IOAPIC line falls, an enabled legacy line is still high.
    a_r6_isa_outlasts_io: assert property (@(posedge clk) disable iff (rst)
      ($fell(ioapic_irq[p]) && ($past(route_q[p]) < 8'd16))
        |-> isa_irq[$past(route_q[p][3:0])]);
  end

endmodule

bind pirq_router pirq_router_chk #(
  .NUM_DEV(NUM_DEV),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .dev_req   (dev_req),
  .isa_irq   (isa_irq),
  .ioapic_irq(ioapic_irq),
  .route_q   (route_q)
);

// File: tb/pirq_router_tb_top.sv
module pirq_router_tb_top;

  localparam int NUM_DEV = 4;
  localparam int DEVNUM_W = 5;

  logic                             clk = 1'b0;
  logic                             rst = 1'b1;
  logic                             cfg_wr = 1'b0;
  logic [7:0]                       cfg_addr = 8'h00;
  logic [7:0]                       cfg_wdata = 8'h00;
  logic [7:0]                       cfg_rdata;
  logic [NUM_DEV-1:0][DEVNUM_W-1:0] dev_num = '0;
  logic [NUM_DEV-1:0][2:0]          dev_pin = '0;
  logic [NUM_DEV-1:0]               dev_req = '0;
  logic [15:0]                      isa_irq;
  logic [3:0]                       ioapic_irq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10ns clk = ~clk;

  pirq_router #(
    .NUM_DEV (NUM_DEV),
    .DEVNUM_W(DEVNUM_W),
    .ADDR_W  (8)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .dev_num   (dev_num),
    .dev_pin   (dev_pin),
    .dev_req   (dev_req),
    .isa_irq   (isa_irq),
    .ioapic_irq(ioapic_irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    cfg_wr = 1'b1;
    cfg_addr = a;
    cfg_wdata = d;
    step(1);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input string req, input logic [7:0] a, input logic [7:0] exp);
    cfg_addr = a;
    #1ns;
    chk(req, $sformatf("read 0x%0h", a), {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  task automatic quiet();
    dev_req = '0;
    step(4);
  endtask

  function automatic int lane_of(input int num, input int pin);
    return ((pin - 1) + (num - 1) + 8) % 4;
  endfunction

  // R1
  task automatic t_reset();
    chk("R1", "isa after reset", {16'h0, isa_irq}, 32'h0);
    chk("R1", "ioapic after reset", {28'h0, ioapic_irq}, 32'h0);
    cfg_read("R1", 8'h60, 8'h80);
    cfg_read("R1", 8'h61, 8'h80);
    cfg_read("R1", 8'h62, 8'h80);
    cfg_read("R1", 8'h63, 8'h80);
    cfg_read("R1", 8'h70, 8'h80);
  endtask

  // R6 with R2 and R4: lane A routed to line 5
  task automatic t_timing();
    cfg_write(8'h60, 8'h05);
    dev_num[0] = 5'd1;
    dev_pin[0] = 3'd1;
    dev_req[0] = 1'b1;
    step(1);
    chk("R6", "isa after E", {16'h0, isa_irq}, 32'h0);
    step(1);
    chk("R6", "isa after E+1", {16'h0, isa_irq}, 32'h20);
    chk("R6", "io after E+1", {28'h0, ioapic_irq}, 32'h0);
    step(1);
    chk("R6", "io after E+2", {28'h0, ioapic_irq}, 32'h1);
    step(2);
    dev_req[0] = 1'b0;
    step(1);
    chk("R6", "io after F", {28'h0, ioapic_irq}, 32'h1);
    step(1);
    chk("R6", "io after F+1", {28'h0, ioapic_irq}, 32'h0);
    chk("R6", "isa after F+1", {16'h0, isa_irq}, 32'h20);
    step(1);
    chk("R6", "isa after F+2", {16'h0, isa_irq}, 32'h0);
    quiet();
  endtask

  // R2: swizzle of one source
  task automatic t_swizzle(input int num, input int pin);
    dev_num[0] = DEVNUM_W'(num);
    dev_pin[0] = 3'(pin);
    dev_req[0] = 1'b1;
    step(4);
    chk("R2", $sformatf("lane of dev %0d pin %0d", num, pin), {28'h0, ioapic_irq},
        32'(1 << lane_of(num, pin)));
    quiet();
  endtask

  // R3 and R4: disabled routes keep the IOAPIC path alive
  task automatic t_disabled();
    cfg_write(8'h61, 8'h83);
    dev_num[0] = 5'd1;
    dev_pin[0] = 3'd2;
    dev_req[0] = 1'b1;
    step(4);
    chk("R4", "isa with lane B disabled", {16'h0, isa_irq}, 32'h0);
    chk("R3", "io with lane B disabled", {28'h0, ioapic_irq}, 32'h2);
    quiet();
  endtask

  // R3: two sources on one lane
  task automatic t_share_lane();
    dev_num[2] = 5'd2; dev_pin[2] = 3'd1;
    dev_num[3] = 5'd1; dev_pin[3] = 3'd2;
    dev_req[2] = 1'b1;
    dev_req[3] = 1'b1;
    step(4);
    chk("R3", "shared lane both up", {28'h0, ioapic_irq}, 32'h2);
    dev_req[2] = 1'b0;
    step(4);
    chk("R3", "shared lane one left", {28'h0, ioapic_irq}, 32'h2);
    dev_req[3] = 1'b0;
    step(4);
    chk("R3", "shared lane none left", {28'h0, ioapic_irq}, 32'h0);
  endtask

  // R5: two lanes onto one ISA line
  task automatic t_share_isa();
    cfg_write(8'h61, 8'h09);
    cfg_write(8'h62, 8'h09);
    dev_num[0] = 5'd1; dev_pin[0] = 3'd2;
    dev_num[1] = 5'd1; dev_pin[1] = 3'd3;
    dev_req[0] = 1'b1;
    dev_req[1] = 1'b1;
    step(4);
    chk("R5", "line 9 from B and C", {16'h0, isa_irq}, 32'h200);
    dev_req[0] = 1'b0;
    step(4);
    chk("R5", "line 9 from C only", {16'h0, isa_irq}, 32'h200);
    chk("R5", "io C only", {28'h0, ioapic_irq}, 32'h4);
    dev_req[1] = 1'b0;
    step(4);
    chk("R5", "line 9 released", {16'h0, isa_irq}, 32'h0);
  endtask

  // R7 then R8 on a live route
  task automatic t_rewrite_and_unimpl();
    cfg_write(8'h60, 8'h05);
    dev_num[0] = 5'd1; dev_pin[0] = 3'd1;
    dev_req[0] = 1'b1;
    step(4);
    chk("R7", "old route steady", {16'h0, isa_irq}, 32'h20);
    cfg_write(8'h60, 8'h0A);
    chk("R7", "cycle of write", {16'h0, isa_irq}, 32'h20);
    step(1);
    chk("R7", "cycle after write", {16'h0, isa_irq}, 32'h400);
    cfg_write(8'h64, 8'hFF);
    cfg_write(8'h71, 8'hFF);
    cfg_write(8'h5F, 8'h00);
    step(2);
    chk("R8", "isa after stray writes", {16'h0, isa_irq}, 32'h400);
    chk("R8", "io after stray writes", {28'h0, ioapic_irq}, 32'h1);
    cfg_read("R8", 8'h64, 8'h00);
    cfg_read("R8", 8'h71, 8'h00);
    cfg_read("R8", 8'h5F, 8'h00);
    cfg_read("R8", 8'h60, 8'h0A);
    quiet();
  endtask

  // R9
  task automatic t_reserved();
    cfg_write(8'h61, 8'h7F);
    cfg_read("R9", 8'h61, 8'h0F);
    cfg_write(8'h70, 8'hFF);
    cfg_read("R9", 8'h70, 8'h8F);
  endtask

  // R10
  task automatic t_no_pin();
    cfg_write(8'h60, 8'h01);
    cfg_write(8'h61, 8'h02);
    cfg_write(8'h62, 8'h03);
    cfg_write(8'h63, 8'h04);
    dev_num[0] = 5'd1; dev_pin[0] = 3'd0;
    dev_num[1] = 5'd2; dev_pin[1] = 3'd5;
    dev_num[2] = 5'd3; dev_pin[2] = 3'd7;
    dev_req[2:0] = 3'b111;
    step(4);
    chk("R10", "isa with invalid pins", {16'h0, isa_irq}, 32'h0);
    chk("R10", "io with invalid pins", {28'h0, ioapic_irq}, 32'h0);
    quiet();
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_timing();
    t_swizzle(1, 1);
    t_swizzle(3, 4);
    t_swizzle(2, 3);
    t_swizzle(5, 2);
    t_swizzle(0, 1);
    t_disabled();
    t_share_lane();
    t_share_isa();
    t_rewrite_and_unimpl();
    t_reserved();
    t_no_pin();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule